// File: doc/BRIEF.md
# Addressable SPI Slave Front End with Chain Passthrough

This block is the serial front end for a group of identical devices that share one SPI master. The devices are wired either as a daisy chain, where each serial output feeds the next device's serial input, or as a parallel bus with common inputs and a common output line. Every device sees the first byte of a frame. Only the device whose strap address matches that byte takes part in the data exchange. Every other device stays out of the way: it forwards its input in chain wiring, or releases the shared output in bus wiring.

All logic runs on a fast system clock. The select, bit clock and serial input are brought in through synchronizers, and bit-clock edges are found from the synchronized copies. In data mode the block works in SPI mode 0: it samples on the rising bit-clock edge and shifts its response out MSB first on the falling edge. Each received byte is presented in parallel with a one-cycle strobe. While no frame is running, the block can raise its serial output to report a pending interrupt to the master.

Top module: `spi_addr_slave`

## Requirements
- R1: After reset, with interrupt signaling off, `soc_o`=0, `sob_oe_o`=0, `sob_o`=0 and `rx_valid_o`=0.
- R2: During the first byte of a frame in chain mode (`bus_mode_i`=0), `soc_o` follows `si_i` combinationally, with no clock delay.
- R3: The first byte is received MSB first. Its bits [1:0] are compared with `dev_addr_i`, and bits [7:2] are ignored. On a match the device enters data mode and drives bit 7 down to bit 0 of its response byte, each bit valid before the rising bit-clock edge that samples it.
- R4: On a mismatch the device stays transparent until the select rises: in chain mode `soc_o` equals `si_i`, and no `rx_valid_o` pulse occurs.
- R5: In data mode every 8 rising bit-clock edges complete one byte. That byte is placed on `rx_byte_o` (first bit received in bit 7), and `rx_valid_o` is high for exactly one clock.
- R6: In bus mode `soc_o` is held at 0. `sob_oe_o` is 1 only in data mode or while signaling an interrupt. `sob_o` carries the response bits and is 0 whenever `sob_oe_o` is 0. In chain mode `sob_oe_o` stays 0.
- R7: While idle (select high) with `irq_en_i`=1 and `irq_pend_i`=1, chain mode drives `soc_o`=1 and bus mode drives `sob_oe_o`=1 with `sob_o`=1. No interrupt is shown while a frame is active.
- R8: While idle with interrupt signaling off or nothing pending, chain mode forwards `si_i` to `soc_o` (this passes an upstream interrupt through), and bus mode leaves `sob_oe_o`=0.
- R9: A rising select returns the block to idle at any point, including partway through a byte. A partly received byte produces no strobe, and the next frame starts again at bit 0 of its address byte.
- R10: `tx_byte_i` is captured on the rising edge that completes each byte, including the address byte. It supplies the response for the following byte, and later changes do not affect that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock from master |
| ncs_i | input | 1 | Active-low frame select |
| si_i | input | 1 | Serial data in (master or upstream device) |
| dev_addr_i | input | ADDR_W | Strap device address |
| bus_mode_i | input | 1 | 1 = parallel bus wiring, 0 = daisy chain |
| irq_en_i | input | 1 | Strap enabling interrupt signaling on the serial output |
| irq_pend_i | input | 1 | Interrupt pending from device logic |
| tx_byte_i | input | BYTE_W | Response byte for the next byte slot |
| rx_byte_o | output | BYTE_W | Last complete received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_byte_o |
| soc_o | output | 1 | Chain serial output |
| sob_o | output | 1 | Bus serial output value |
| sob_oe_o | output | 1 | Bus serial output enable (0 = high impedance) |

## Verification
The hardest case to reach is the falling bit-clock edge that follows the last address bit. That edge must not shift the freshly loaded response, so the first data bit survives into the next rising edge. The bench drives complete frames for all sixteen pairs of strap address and target address, in both wirings, and checks the first response bit of every addressed frame, alongside the passthrough and tristate checks for the unaddressed ones. A frame aborted four bits into a data byte, followed at once by a fresh addressed frame, exercises the reset of the bit count on select.

// File: rtl/spi_addr_pkg.sv
`timescale 1ns/1ps
package spi_addr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_PASS = 2'd3
  } frame_state_e;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
module spi_frame_ctrl
  import spi_addr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ncs_i,
  input  logic              sck_rise_i,
  input  logic              si_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output frame_state_e      state_o,
  output logic              byte_end_o,
  output logic              mid_byte_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W-1);

  frame_state_e      st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, rx_q;
  logic              vld_q;
  logic [BYTE_W-1:0] sh_nxt;
  logic              last_bit;

  assign sh_nxt   = {sh_q[BYTE_W-2:0], si_i};
  assign last_bit = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      rx_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (ncs_i) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else begin
        if (st_q == ST_IDLE) st_q <= ST_ADDR;
        if (sck_rise_i) begin
          sh_q  <= sh_nxt;
          cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
          if (last_bit) begin
            case (st_q)
              ST_ADDR: st_q <= (sh_nxt[ADDR_W-1:0] == dev_addr_i) ? ST_DATA : ST_PASS;
              ST_DATA: begin
                rx_q  <= sh_nxt;
                vld_q <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign state_o    = st_q;
  assign byte_end_o = sck_rise_i & last_bit & ~ncs_i;
  assign mid_byte_o = (cnt_q != '0);
  assign rx_byte_o  = rx_q;
  assign rx_valid_o = vld_q;
endmodule

// File: rtl/spi_tx_shifter.sv
`timescale 1ns/1ps
module spi_tx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              msb_o
);
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (load_i) sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
  end

  assign msb_o = sh_q[BYTE_W-1];
endmodule

// File: rtl/spi_addr_slave.sv
`timescale 1ns/1ps
module spi_addr_slave
  import spi_addr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ncs_i,
  input  logic              si_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              bus_mode_i,
  input  logic              irq_en_i,
  input  logic              irq_pend_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              soc_o,
  output logic              sob_o,
  output logic              sob_oe_o
);
  logic [2:0]   raw, syn;
  logic         ncs_s, sck_s, si_s, sck_q;
  logic         sck_rise, sck_fall;
  frame_state_e state;
  logic         byte_end, mid_byte, tx_msb;
  logic         in_data, irq_act;

  assign raw = {ncs_i, sck_i, si_i};

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {ncs_s, sck_s, si_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  spi_frame_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ncs_i(ncs_s), .sck_rise_i(sck_rise),
    .si_i(si_s), .dev_addr_i(dev_addr_i), .state_o(state),
    .byte_end_o(byte_end), .mid_byte_o(mid_byte),
    .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o)
  );

  assign in_data = (state == ST_DATA);

  // the fall right after a byte boundary must not consume the fresh MSB
  spi_tx_shifter #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(byte_end),
    .shift_i(sck_fall & mid_byte & in_data),
    .data_i(tx_byte_i), .msb_o(tx_msb)
  );

  assign irq_act = irq_en_i & irq_pend_i & (state == ST_IDLE);

  always_comb begin
    soc_o    = 1'b0;
    sob_o    = 1'b0;
    sob_oe_o = 1'b0;
    if (bus_mode_i) begin
      sob_oe_o = in_data | irq_act;
      sob_o    = in_data ? tx_msb : irq_act;
    end else begin
      soc_o = in_data ? tx_msb : (si_i | irq_act);
    end
  end
endmodule

// File: rtl/spi_addr_slave_chk.sv
`timescale 1ns/1ps
module spi_addr_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ncs_i,
  input logic bus_mode_i,
  input logic irq_en_i,
  input logic irq_pend_i,
  input logic rx_valid_o,
  input logic soc_o,
  input logic sob_o,
  input logic sob_oe_o
);
  logic [2:0] hi_cnt;
  logic       settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else if (!ncs_i) hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  assign settled = (hi_cnt >= 3'd4);

  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r9_no_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> !rx_valid_o);
  a_r7_irq_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && bus_mode_i && irq_en_i && irq_pend_i) |-> (sob_oe_o && sob_o));
  a_r8_irq_off_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && bus_mode_i && !irq_en_i) |-> !sob_oe_o);
  a_r6_chain_no_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_mode_i |-> !sob_oe_o);
  a_r6_bus_soc_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_mode_i |-> !soc_o);
  a_r6_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sob_oe_o |-> !sob_o);
endmodule

bind spi_addr_slave spi_addr_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ncs_i(ncs_i), .bus_mode_i(bus_mode_i),
  .irq_en_i(irq_en_i), .irq_pend_i(irq_pend_i), .rx_valid_o(rx_valid_o),
  .soc_o(soc_o), .sob_o(sob_o), .sob_oe_o(sob_oe_o)
);

// File: tb/sim_spi_addr_slave.sv
`timescale 1ns/1ps
module sim_spi_addr_slave;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, ncs = 1'b1, si = 1'b0;
  logic [1:0] dev_addr = 2'd0;
  logic bus_mode = 1'b0, irq_en = 1'b0, irq_pend = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic rx_valid, soc, sob, sob_oe;

  int n_chk = 0, n_err = 0, vcnt = 0;
  logic [7:0] vbyte = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_addr_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ncs_i(ncs), .si_i(si),
    .dev_addr_i(dev_addr), .bus_mode_i(bus_mode), .irq_en_i(irq_en),
    .irq_pend_i(irq_pend), .tx_byte_i(tx_byte), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid), .soc_o(soc), .sob_o(sob), .sob_oe_o(sob_oe)
  );

  always @(negedge clk) if (rx_valid) begin
    vcnt++;
    vbyte = rx_byte;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] txv(input int k, input logic [7:0] a);
    return 8'hA5 ^ 8'(k * 60) ^ a;
  endfunction

  function automatic logic [7:0] rdv(input int k, input logic [7:0] a);
    return ~txv(k, a) + 8'(k);
  endfunction

  task automatic chk_idle(input string tag);
    logic want;
    want = irq_en & irq_pend;
    #1;
    if (bus_mode) begin
      chk({tag, " bus oe"}, 32'(sob_oe), 32'(want));
      chk({tag, " bus sob"}, 32'(sob), 32'(want));
      chk({tag, " bus soc"}, 32'(soc), 0);
    end else begin
      chk({tag, " chain soc"}, 32'(soc), 32'(want | si));
      chk({tag, " chain oe"}, 32'(sob_oe), 0);
    end
  endtask

  // nbits beyond the address byte; a non-multiple of 8 aborts mid-byte
  task automatic frame(input logic [7:0] abyte, input int nbits);
    logic match, bitv;
    int v0, total;
    match = (abyte[1:0] == dev_addr);
    total = 8 + nbits;
    v0 = vcnt;
    tx_byte = txv(0, abyte);
    @(negedge clk);
    ncs = 1'b0;
    for (int n = 0; n < total; n++) begin
      int b, i;
      logic [7:0] rd;
      b = n / 8;
      i = n % 8;
      rd = (b == 0) ? abyte : rdv(b - 1, abyte);
      bitv = rd[7 - i];
      @(negedge clk);
      si = bitv;
      #1;
      if (!bus_mode && n > 0 && (b == 0 || !match))
        chk((b == 0) ? "R2 comb pass" : "R4 comb pass", 32'(soc), 32'(bitv));
      repeat (HALF) @(negedge clk);
      if (bus_mode) begin
        chk("R6 bus soc", 32'(soc), 0);
        chk("R6 bus oe", 32'(sob_oe), 32'(b > 0 && match));
        if (b > 0 && match) chk("R3 bus tx bit", 32'(sob), 32'(txv(b - 1, abyte) >> (7 - i)) & 1);
        else chk("R6 bus sob off", 32'(sob), 0);
      end else if (b > 0 && match) begin
        chk("R3 chain tx bit", 32'(soc), 32'(txv(b - 1, abyte) >> (7 - i)) & 1);
      end else begin
        chk((b == 0) ? "R2 addr pass" : "R4 pass", 32'(soc), 32'(bitv));
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i == 7) begin
        tx_byte = txv(b + 1, abyte); // R10: later change must not touch loaded byte
        if (b > 0) begin
          chk("R5 strobe count", 32'(vcnt), 32'(v0 + (match ? b : 0)));
          if (match) chk("R5 rx byte", 32'(vbyte), 32'(rd));
        end
      end
      sck = 1'b0;
    end
    @(negedge clk);
    ncs = 1'b1;
    si = 1'b0;
    repeat (HALF) @(negedge clk);
    if (total % 8 != 0)
      chk("R9 abort no strobe", 32'(vcnt), 32'(v0 + (match ? (total / 8 - 1) : 0)));
    chk_idle("R7 post frame idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset soc", 32'(soc), 0);
    chk("R1 reset oe", 32'(sob_oe), 0);
    chk("R1 reset sob", 32'(sob), 0);
    chk("R1 reset valid", 32'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 2; p++) begin
          @(negedge clk);
          bus_mode = m[0];
          irq_en = e[0];
          irq_pend = p[0];
          chk_idle((e == 1 && p == 1) ? "R7 idle irq" : "R8 idle quiet");
        end
    @(negedge clk);
    bus_mode = 1'b0;
    irq_en = 1'b0;
    si = 1'b1;
    #1;
    chk("R8 chain forward upstream irq", 32'(soc), 1);
    @(negedge clk);
    si = 1'b0;

    for (int m = 0; m < 2; m++)
      for (int own = 0; own < 4; own++)
        for (int tgt = 0; tgt < 4; tgt++) begin
          logic [7:0] ab;
          @(negedge clk);
          bus_mode = m[0];
          dev_addr = own[1:0];
          irq_en = 1'b1;
          irq_pend = own[0] ^ tgt[0];
          ab = {6'(tgt * 37 + own * 11 + m * 5), tgt[1:0]};
          frame(ab, 16);
        end

    @(negedge clk);
    bus_mode = 1'b0;
    irq_en = 1'b0;
    irq_pend = 1'b0;
    dev_addr = 2'd2;
    frame(8'hC6, 12);
    frame(8'h5A, 8);
    frame(8'h5B, 8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule